// File: doc/BRIEF.md
# Hybrid Coherence Request Router

After a cache miss at a requester core, this block decides which node receives the coherence request and what kind of request it is. It takes the missing address, a read/write flag and the result of a pattern-table lookup that ran beside it: a hit flag and the base address of the matched pattern.

Two home-node indices are always computed in parallel. The line home comes from the missing address at 64-byte granularity. The page home comes from the pattern base at 2 KB granularity. On a pattern hit the block emits a speculative message carrying the pattern base, addressed to the page home. Otherwise it emits an ordinary message carrying the miss address, addressed to the line home.

The decision is registered, so both kinds of request leave one cycle after they are accepted. The outgoing message uses a valid/ready handshake, and the miss input is accepted only when the output register is free or is being drained in the same cycle.

Top module: `cohRouter`

## Requirements
- R1: After reset `msgValid` is low and `missReady` is high.
- R2: A request with `patHit` low is sent to node `(missAddr >> 6) mod NODE_COUNT`, which is bits [6 +: log2(NODE_COUNT)] of the miss address.
- R3: A request with `patHit` high is sent to node `(patBase >> 11) mod NODE_COUNT`, which is bits [11 +: log2(NODE_COUNT)] of the pattern base.
- R4: `msgType` is encoded as 0 for an ordinary read, 1 for an ordinary write, 2 for a speculative read and 3 for a speculative write. Bit 1 equals `patHit` and bit 0 equals `missIsWrite`.
- R5: `msgAddr` carries `patBase` when `patHit` is high and `missAddr` when it is low. The input that is not selected has no effect on the message.
- R6: A miss accepted at a clock edge (`missValid` and `missReady` both high) appears with `msgValid` high right after that edge.
- R7: While `msgValid` is high and `msgReady` is low, `missReady` is low and `msgValid`, `msgDest`, `msgType` and `msgAddr` keep their values.
- R8: When `msgReady` is high, a new miss is accepted in the same cycle that the pending message leaves, so back-to-back misses travel with no idle cycle.
- R9: While `missValid` is low, `patHit`, `patBase`, `missAddr` and `missIsWrite` produce no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A miss request is presented |
| missReady | output | 1 | The miss request is accepted this cycle |
| missAddr | input | ADDR_W | Missing address |
| missIsWrite | input | 1 | 1 for a write miss, 0 for a read miss |
| patHit | input | 1 | The pattern table matched this miss |
| patBase | input | ADDR_W | Base address of the matched pattern |
| msgValid | output | 1 | The outgoing message is valid |
| msgReady | input | 1 | The network takes the message |
| msgDest | output | log2(NODE_COUNT) | Destination home-node index |
| msgType | output | 2 | Message kind, encoded as in R4 |
| msgAddr | output | ADDR_W | Address carried by the message |

## Verification
Two functions can land in the same cycle: draining the pending message to the network and accepting the next miss into the same register. The bench provokes this by holding `msgReady` high while it feeds misses back to back, alternating pattern hits and misses. It counts the stall cycles seen by the driver, which must be zero, and the scoreboard checks that each message leaves intact and in order. It also runs the same traffic against a toggling `msgReady`, so that accepts, stalls and drains interleave, and the scoreboard still has to match every message.

// File: rtl/coh_route_pkg.sv
package coh_route_pkg;

  // Message kind: bit 1 = speculative (pattern path), bit 0 = write
  typedef enum logic [1:0] {
    MSG_LINE_RD = 2'd0,
    MSG_LINE_WR = 2'd1,
    MSG_PAGE_RD = 2'd2,
    MSG_PAGE_WR = 2'd3
  } cohMsg_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new routing decision
    logic hold;  // pending message stalled by the network
  } cohStrobe_t;

endpackage

// File: rtl/cohHomeIndex.sv
// Home-node index at a given granularity: a power-of-two modulo is a bit slice.
module cohHomeIndex #(
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 6,
  parameter int NODE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NODE_W-1:0] node
);
  assign node = addr[SHIFT +: NODE_W];
endmodule

// File: rtl/cohRouteCtrl.sv
module cohRouteCtrl
  import coh_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       msgReady,
  output logic       missReady,
  output logic       msgValid,
  output cohStrobe_t strb
);
  logic validQ;

  assign missReady = !validQ || msgReady;
  assign strb.load = missValid && missReady;
  assign strb.hold = validQ && !msgReady;
  assign msgValid  = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)          validQ <= 1'b0;
    else if (strb.load) validQ <= 1'b1;
    else if (msgReady)  validQ <= 1'b0;
  end

  // R1: an empty output register always accepts
  a_r1_idle_accepts: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |-> missReady);
  // R6: an accepted miss is visible right after the edge
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> msgValid);
  // R7: a stalled message stays valid
  a_r7_keep_valid: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid);
endmodule

// File: rtl/cohRouteDp.sv
module cohRouteDp
  import coh_route_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NODE_COUNT = 16,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 2048,
  localparam int NODE_W    = $clog2(NODE_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cohStrobe_t        strb,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missIsWrite,
  input  logic              patHit,
  input  logic [ADDR_W-1:0] patBase,
  output logic [NODE_W-1:0] msgDest,
  output logic [1:0]        msgType,
  output logic [ADDR_W-1:0] msgAddr
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  logic [NODE_W-1:0] lineHome, pageHome;
  logic [NODE_W-1:0] destQ;
  cohMsg_e           typeQ, typeNext;
  logic [ADDR_W-1:0] addrQ;

  // Both homes are always computed; the hit flag only picks one of them
  cohHomeIndex #(.ADDR_W(ADDR_W), .SHIFT(LINE_SHIFT), .NODE_W(NODE_W))
    uLineHome (.addr(missAddr), .node(lineHome));
  cohHomeIndex #(.ADDR_W(ADDR_W), .SHIFT(PAGE_SHIFT), .NODE_W(NODE_W))
    uPageHome (.addr(patBase), .node(pageHome));

  always_comb begin
    unique case ({patHit, missIsWrite})
      2'b00:   typeNext = MSG_LINE_RD;
      2'b01:   typeNext = MSG_LINE_WR;
      2'b10:   typeNext = MSG_PAGE_RD;
      default: typeNext = MSG_PAGE_WR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ <= '0;
      typeQ <= MSG_LINE_RD;
      addrQ <= '0;
    end else if (strb.load) begin
      destQ <= patHit ? pageHome : lineHome;
      typeQ <= typeNext;
      addrQ <= patHit ? patBase : missAddr;
    end
  end

  assign msgDest = destQ;
  assign msgType = typeQ;
  assign msgAddr = addrQ;

  // R7: fields frozen while the network stalls
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> ($stable(destQ) && $stable(typeQ) && $stable(addrQ)));
  // R4: a pattern hit yields a speculative kind
  a_r4_spec_kind: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && patHit) |=> typeQ[1]);
  // R5: a pattern miss carries the miss address
  a_r5_line_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !patHit) |=> (addrQ == $past(missAddr)));
endmodule

// File: rtl/cohRouter.sv
module cohRouter
  import coh_route_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NODE_COUNT = 16,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 2048,
  localparam int NODE_W    = $clog2(NODE_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  output logic              missReady,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missIsWrite,
  input  logic              patHit,
  input  logic [ADDR_W-1:0] patBase,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [NODE_W-1:0] msgDest,
  output logic [1:0]        msgType,
  output logic [ADDR_W-1:0] msgAddr
);
  cohStrobe_t strb;

  cohRouteCtrl uCtrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .msgReady(msgReady),
    .missReady(missReady), .msgValid(msgValid), .strb(strb)
  );

  cohRouteDp #(
    .ADDR_W(ADDR_W), .NODE_COUNT(NODE_COUNT),
    .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .missAddr(missAddr),
    .missIsWrite(missIsWrite), .patHit(patHit), .patBase(patBase),
    .msgDest(msgDest), .msgType(msgType), .msgAddr(msgAddr)
  );
endmodule

// File: tb/sim_cohRouter.sv
`timescale 1ns/1ps
module sim_cohRouter;
  localparam int AW = 32;
  localparam int NC = 16;
  localparam int NW = 4;

  typedef struct packed {
    logic [NW-1:0] dest;
    logic [1:0]    kind;
    logic [AW-1:0] addr;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic missValid = 0, missIsWrite = 0, patHit = 0, msgReady = 1;
  logic [AW-1:0] missAddr = '0, patBase = '0;
  logic missReady, msgValid;
  logic [NW-1:0] msgDest;
  logic [1:0] msgType;
  logic [AW-1:0] msgAddr;

  int checks = 0, failures = 0, stalls = 0, cycles = 0, readyMode = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  cohRouter u0 (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missReady(missReady),
    .missAddr(missAddr), .missIsWrite(missIsWrite), .patHit(patHit),
    .patBase(patBase), .msgValid(msgValid), .msgReady(msgReady),
    .msgDest(msgDest), .msgType(msgType), .msgAddr(msgAddr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // readyMode 0: always ready, 1: toggling, 2: stalled
  always @(negedge clk) begin
    cycles++;
    case (readyMode)
      0: msgReady <= 1'b1;
      1: msgReady <= cycles[0] ^ cycles[2];
      default: msgReady <= 1'b0;
    endcase
  end

  // Monitor / scoreboard: sample between edges
  always @(negedge clk) begin
    #1;
    if (rstN && msgValid && msgReady) begin
      if (sb.size() == 0) begin
        check(0, "R9 unexpected message", 64'(msgAddr), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(msgDest == e.dest, e.kind[1] ? "R3 page home" : "R2 line home", 64'(msgDest), 64'(e.dest));
        check(msgType == e.kind, "R4 kind", 64'(msgType), 64'(e.kind));
        check(msgAddr == e.addr, "R5 address", 64'(msgAddr), 64'(e.addr));
      end
    end
  end

  // Driver: called right after a negedge; returns at the negedge following acceptance
  task automatic sendMiss(input logic [AW-1:0] a, input bit wr, input bit hit, input logic [AW-1:0] b);
    exp_t e;
    bit ok;
    missValid = 1; missAddr = a; missIsWrite = wr; patHit = hit; patBase = b;
    e.dest = hit ? NW'((b >> 11) % NC) : NW'((a >> 6) % NC);
    e.kind = {hit, wr};
    e.addr = hit ? b : a;
    do begin
      #1 ok = missReady;
      if (!ok) begin stalls++; @(negedge clk); end
    end while (!ok);
    sb.push_back(e);
    @(negedge clk);
    missValid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(msgValid == 0, "R1 msgValid after reset", 64'(msgValid), 0);
    check(missReady == 1, "R1 missReady after reset", 64'(missReady), 1);
    @(negedge clk);

    // R9: inputs wiggle with missValid low, nothing emitted
    for (int i = 0; i < 6; i++) begin
      patHit = i[0]; patBase = 32'h1234_5800 + 32'(i); missAddr = 32'hABC0_0040 * 32'(i + 1); missIsWrite = i[1];
      @(negedge clk);
      #1 check(msgValid == 0, "R9 no message while idle", 64'(msgValid), 0);
    end

    // R6 latency and R2/R4 line read
    sendMiss(32'h0000_03C0, 0, 0, 32'hFFFF_FFFF);
    #1 check(msgValid == 1, "R6 valid one cycle after accept", 64'(msgValid), 1);
    drain();

    // R3/R5: page home from pattern base, unrelated miss address
    sendMiss(32'h0000_0040, 1, 1, 32'h0000_7800);
    sendMiss(32'h0001_F7C0, 1, 0, 32'h0000_0000);
    sendMiss(32'h0000_0000, 0, 1, 32'h0008_F800);
    drain();

    // R8: back-to-back, ready held high, no stalls allowed
    stalls = 0;
    for (int i = 0; i < 8; i++)
      sendMiss(32'h1000_0000 + 32'(i * 64), i[1], i[0], 32'h2000_0000 + 32'(i * 2048));
    check(stalls == 0, "R8 back-to-back without bubble", 64'(stalls), 0);
    drain();

    // R7: stall holds message and blocks input
    readyMode = 2;
    @(negedge clk);
    sendMiss(32'h0000_0AC0, 1, 0, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    check(msgValid == 1, "R7 valid held", 64'(msgValid), 1);
    check(missReady == 0, "R7 input blocked", 64'(missReady), 0);
    check(msgDest == 4'hB, "R7 dest held", 64'(msgDest), 64'hB);
    check(msgType == 2'd1, "R7 kind held", 64'(msgType), 1);
    check(msgAddr == 32'h0000_0AC0, "R7 addr held", 64'(msgAddr), 64'hAC0);
    readyMode = 0;
    drain();

    // Mixed traffic under toggling ready
    readyMode = 1;
    for (int i = 0; i < 40; i++)
      sendMiss(32'h0000_0000 + 32'(i * 32'h1C4), i[0], i[2] ^ i[0], 32'h0000_1000 + 32'(i * 32'h2A00));
    readyMode = 0;
    drain();
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R8 all messages delivered", 64'(sb.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule